// File: doc/BRIEF.md
# Event-Qualified Performance Counter Unit

This block holds a pair of performance-monitoring counters. Each counter has its own control register. The control register picks one event source from a vector of source groups. Each group carries eight sub-event lines, and the control register qualifies that group with an 8-bit mask. In event mode a counter adds, every clock, the number of qualified sub-event lines that are high. In cycle mode it adds one for every clock in which any qualified line is high, which measures how long a condition lasts. Counting does not depend on the privilege level of the running code.

Software reaches the control and counter registers through a general access port. This port checks the privilege level of the request: only level 0 may read or write, and any other level gets a fault flag with no effect on the registers. A second port reads either counter at any time. It cannot write anything and cannot reach the control registers.

Top module: `evq_perf_counters`

## Requirements
- R1: After reset both control registers and both counters read zero, so both counters are disabled.
- R2: The control word layout is: event select in bits 7:0, unit mask in bits 15:8, cycle mode in bit 16, enable in bit 20, and sticky overflow in bit 31. All other bits read zero. A select code equal to or above the number of sources (8) chooses no source, and the counter does not advance.
- R3: In event mode an enabled counter adds, on every clock, the number of set bits of (lines of the selected source AND unit mask). Source s occupies ev_lines[8s+7:8s], and mask bit j qualifies line j of that source.
- R4: In cycle mode (bit 16 = 1) an enabled counter adds exactly 1 on every clock in which at least one qualified line is high, however many lines are high.
- R5: While bit 20 is 0 a counter keeps its value, whatever the event lines do.
- R6: Counters are 40 bits wide and wrap modulo 2^40. A wrap sets bit 31 of that counter's control register. That bit stays set until a control write loads a new value for it.
- R7: The access port decodes addresses as follows: 0 is control 0, 1 is control 1, 2 is counter 0, and 3 is counter 1. Read data is combinational. A write takes effect at the next rising edge. A counter write loads acc_wdata[39:0] in place of that cycle's increment. Counter reads are zero-extended to 64 bits.
- R8: A request with acc_priv not equal to 0 raises acc_fault, returns zero read data, and changes no register.
- R9: rd_data returns the counter chosen by rd_sel (0 or 1) without any privilege check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_lines | input | 64 | Eight source groups of eight sub-event lines each |
| acc_en | input | 1 | Access request valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register address |
| acc_priv | input | 2 | Privilege level of the requester (0 = most privileged) |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data (zero when faulted or idle) |
| acc_fault | output | 1 | Request refused for privilege |
| rd_sel | input | 1 | Counter index for the read-only port |
| rd_data | output | 40 | Selected counter value |

## Verification
The main function is exercised with a table of patterns. A full mask against a partially active source separates popcount summing from one-per-cycle counting. A partial mask separates masking from plain source selection. The same pattern run in cycle mode separates the two modes. A mask that is disjoint from the active lines separates "qualified" from "any activity". Further patterns cover a quiet selected source, a disabled counter, and an out-of-range select, which show that the correct group is routed and that enable and select gate counting. Directed cases cover the wrap and sticky overflow, a counter load that collides with live events, zero extension, and refused accesses.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int SEL_W    = 8;
   localparam int MASK_W   = 8;
   localparam int CTL_W    = 32;
   localparam int SEL_LSB  = 0;
   localparam int MASK_LSB = 8;
   localparam int DUR_BIT  = 16;
   localparam int EN_BIT   = 20;
   localparam int OVF_BIT  = 31;

   typedef enum logic {
      CNT_EVENTS = 1'b0,
      CNT_CYCLES = 1'b1
   } pmc_mode_e;

   typedef struct packed {
      logic              ovf;
      logic              en;
      pmc_mode_e         mode;
      logic [MASK_W-1:0] mask;
      logic [SEL_W-1:0]  sel;
   } pmc_ctl_t;

   function automatic logic [CTL_W-1:0] ctl_pack(input pmc_ctl_t c);
      logic [CTL_W-1:0] w;
      w = '0;
      w[SEL_LSB +: SEL_W]   = c.sel;
      w[MASK_LSB +: MASK_W] = c.mask;
      w[DUR_BIT]            = (c.mode == CNT_CYCLES);
      w[EN_BIT]             = c.en;
      w[OVF_BIT]            = c.ovf;
      return w;
   endfunction
endpackage

// File: rtl/pmc_evt_qual.sv
module pmc_evt_qual
   import pmc_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter bit MULTI_HIT = 1'b1,
   parameter int INC_W     = 4,
   localparam int LINE_W   = NUM_SRC * MASK_W
) (
   input  logic [LINE_W-1:0] ev_lines,
   input  logic [SEL_W-1:0]  sel,
   input  logic [MASK_W-1:0] mask,
   input  pmc_mode_e         mode,
   output logic [INC_W-1:0]  inc
);
   logic [MASK_W-1:0] src_lines;
   logic [MASK_W-1:0] hits;
   logic [INC_W-1:0]  tally;

   always_comb begin
      src_lines = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (sel == SEL_W'(s)) src_lines = ev_lines[s*MASK_W +: MASK_W];
      end
   end

   assign hits = src_lines & mask;

   generate
      if (MULTI_HIT) begin : g_sum
         always_comb begin
            tally = '0;
            for (int j = 0; j < MASK_W; j++) tally = tally + INC_W'(hits[j]);
         end
      end else begin : g_any
         assign tally = INC_W'(|hits);
      end
   endgenerate

   assign inc = (mode == CNT_CYCLES) ? INC_W'(|hits) : tally;
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
   import pmc_pkg::*;
#(
   parameter int CNT_W  = 40,
   parameter int INC_W  = 4,
   parameter int WR_W   = 40,
   localparam int SUM_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             cnt_we,
   input  logic [WR_W-1:0]  wdata,
   input  logic [INC_W-1:0] inc,
   output pmc_ctl_t         ctl_o,
   output logic [CNT_W-1:0] cnt_o
);
   pmc_ctl_t         ctl_q;
   pmc_ctl_t         ctl_d;
   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum;
   logic             advance;
   logic             unused_ctl_bits;

   always_comb begin
      ctl_d.sel  = wdata[SEL_LSB +: SEL_W];
      ctl_d.mask = wdata[MASK_LSB +: MASK_W];
      ctl_d.mode = wdata[DUR_BIT] ? CNT_CYCLES : CNT_EVENTS;
      ctl_d.en   = wdata[EN_BIT];
      ctl_d.ovf  = wdata[OVF_BIT];
   end
   assign unused_ctl_bits = ^wdata[CTL_W-1:0];

   assign sum     = {1'b0, cnt_q} + SUM_W'(inc);
   assign advance = ctl_q.en && !cnt_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cnt_q <= '0;
      end else begin
         if (cnt_we)       cnt_q <= wdata[CNT_W-1:0];
         else if (advance) cnt_q <= sum[CNT_W-1:0];

         if (ctl_we)                     ctl_q     <= ctl_d;
         else if (advance && sum[CNT_W]) ctl_q.ovf <= 1'b1;
      end
   end

   assign ctl_o = ctl_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/pmc_access.sv
module pmc_access
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 2,
   parameter int CNT_W   = 40,
   parameter int DATA_W  = 64,
   parameter int PRIV_W  = 2,
   parameter int ADDR_W  = 2,
   parameter int RSEL_W  = 1
) (
   input  logic                     acc_en,
   input  logic                     acc_wr,
   input  logic [ADDR_W-1:0]        acc_addr,
   input  logic [PRIV_W-1:0]        acc_priv,
   input  logic [NUM_CTR*CTL_W-1:0] ctl_words,
   input  logic [NUM_CTR*CNT_W-1:0] cnt_flat,
   input  logic [RSEL_W-1:0]        rd_sel,
   output logic [NUM_CTR-1:0]       ctl_we,
   output logic [NUM_CTR-1:0]       cnt_we,
   output logic [DATA_W-1:0]        acc_rdata,
   output logic                     acc_fault,
   output logic [CNT_W-1:0]         rd_data
);
   logic granted;

   assign granted   = acc_en && (acc_priv == '0);
   assign acc_fault = acc_en && !granted;

   always_comb begin
      ctl_we    = '0;
      cnt_we    = '0;
      acc_rdata = '0;
      for (int k = 0; k < NUM_CTR; k++) begin
         if (granted && acc_addr == ADDR_W'(k)) begin
            ctl_we[k] = acc_wr;
            acc_rdata = DATA_W'(ctl_words[k*CTL_W +: CTL_W]);
         end
         if (granted && acc_addr == ADDR_W'(NUM_CTR + k)) begin
            cnt_we[k] = acc_wr;
            acc_rdata = DATA_W'(cnt_flat[k*CNT_W +: CNT_W]);
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CTR; k++) begin
         if (rd_sel == RSEL_W'(k)) rd_data = cnt_flat[k*CNT_W +: CNT_W];
      end
   end
endmodule

// File: rtl/evq_perf_counters.sv
module evq_perf_counters
   import pmc_pkg::*;
#(
   parameter int NUM_CTR   = 2,
   parameter int NUM_SRC   = 8,
   parameter int CNT_W     = 40,
   parameter int DATA_W    = 64,
   parameter int PRIV_W    = 2,
   parameter bit MULTI_HIT = 1'b1,
   localparam int LINE_W   = NUM_SRC * MASK_W,
   localparam int ADDR_W   = $clog2(2 * NUM_CTR),
   localparam int RSEL_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
   localparam int INC_W    = $clog2(MASK_W + 1),
   localparam int WR_W     = (CNT_W > CTL_W) ? CNT_W : CTL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] ev_lines,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [PRIV_W-1:0] acc_priv,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_fault,
   input  logic [RSEL_W-1:0] rd_sel,
   output logic [CNT_W-1:0]  rd_data
);
   generate
      if (NUM_CTR < 1)                   begin : g_bad_ctr  $error("NUM_CTR must be at least 1");        end
      if (NUM_SRC < 1 || NUM_SRC > 256)  begin : g_bad_src  $error("NUM_SRC must lie in 1..256");        end
      if (CNT_W < 2)                     begin : g_bad_cnt  $error("CNT_W must be at least 2");          end
      if (DATA_W < WR_W)                 begin : g_bad_data $error("DATA_W narrower than a register");   end
      if (PRIV_W < 1)                    begin : g_bad_priv $error("PRIV_W must be at least 1");         end
   endgenerate

   logic [NUM_CTR*CTL_W-1:0] ctl_words;
   logic [NUM_CTR*CNT_W-1:0] cnt_flat;
   logic [NUM_CTR-1:0]       ctl_we;
   logic [NUM_CTR-1:0]       cnt_we;
   logic [NUM_CTR-1:0]       en_vec;
   logic [NUM_CTR-1:0]       dur_vec;
   logic [NUM_CTR-1:0]       ovf_vec;

   generate
      if (DATA_W > WR_W) begin : g_wide_bus
         logic unused_hi_bits;
         assign unused_hi_bits = ^acc_wdata[DATA_W-1:WR_W];
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < NUM_CTR; k++) begin : g_ctr
         pmc_ctl_t         ctl_k;
         logic [INC_W-1:0] inc_k;
         logic [CNT_W-1:0] cnt_k;

         pmc_evt_qual #(
            .NUM_SRC  (NUM_SRC),
            .MULTI_HIT(MULTI_HIT),
            .INC_W    (INC_W)
         ) u_qual (
            .ev_lines(ev_lines),
            .sel     (ctl_k.sel),
            .mask    (ctl_k.mask),
            .mode    (ctl_k.mode),
            .inc     (inc_k)
         );

         pmc_counter #(
            .CNT_W(CNT_W),
            .INC_W(INC_W),
            .WR_W (WR_W)
         ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_we(ctl_we[k]),
            .cnt_we(cnt_we[k]),
            .wdata (acc_wdata[WR_W-1:0]),
            .inc   (inc_k),
            .ctl_o (ctl_k),
            .cnt_o (cnt_k)
         );

         assign ctl_words[k*CTL_W +: CTL_W] = ctl_pack(ctl_k);
         assign cnt_flat[k*CNT_W +: CNT_W]  = cnt_k;
         assign en_vec[k]  = ctl_k.en;
         assign dur_vec[k] = (ctl_k.mode == CNT_CYCLES);
         assign ovf_vec[k] = ctl_k.ovf;
      end
   endgenerate

   pmc_access #(
      .NUM_CTR(NUM_CTR),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .PRIV_W (PRIV_W),
      .ADDR_W (ADDR_W),
      .RSEL_W (RSEL_W)
   ) u_access (
      .acc_en   (acc_en),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .acc_priv (acc_priv),
      .ctl_words(ctl_words),
      .cnt_flat (cnt_flat),
      .rd_sel   (rd_sel),
      .ctl_we   (ctl_we),
      .cnt_we   (cnt_we),
      .acc_rdata(acc_rdata),
      .acc_fault(acc_fault),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
   parameter int NUM_CTR = 2,
   parameter int CNT_W   = 40,
   parameter int PRIV_W  = 2,
   parameter int MAX_INC = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     acc_en,
   input logic [PRIV_W-1:0]        acc_priv,
   input logic [CNT_W-1:0]         wdata_lo,
   input logic [NUM_CTR-1:0]       ctl_we,
   input logic [NUM_CTR-1:0]       cnt_we,
   input logic [NUM_CTR-1:0]       en_vec,
   input logic [NUM_CTR-1:0]       dur_vec,
   input logic [NUM_CTR-1:0]       ovf_vec,
   input logic [NUM_CTR*CNT_W-1:0] cnt_flat
);
   AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_priv != '0) |-> (ctl_we == '0 && cnt_we == '0)); // R8

   genvar k;
   generate
      for (k = 0; k < NUM_CTR; k++) begin : g_chk
         AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[k] && !cnt_we[k]) |=> $stable(cnt_flat[k*CNT_W +: CNT_W])); // R5
         AST_EVENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[k] && !dur_vec[k] && !cnt_we[k]) |=>
            (CNT_W'(cnt_flat[k*CNT_W +: CNT_W] - $past(cnt_flat[k*CNT_W +: CNT_W])) <= CNT_W'(MAX_INC))); // R3
         AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[k] && dur_vec[k] && !cnt_we[k]) |=>
            (CNT_W'(cnt_flat[k*CNT_W +: CNT_W] - $past(cnt_flat[k*CNT_W +: CNT_W])) <= CNT_W'(1))); // R4
         AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_we[k] |=> (cnt_flat[k*CNT_W +: CNT_W] == $past(wdata_lo))); // R7
         AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_vec[k] && !ctl_we[k]) |=> ovf_vec[k]); // R6
      end
   endgenerate
endmodule

bind evq_perf_counters pmc_checker #(
   .NUM_CTR(NUM_CTR),
   .CNT_W  (CNT_W),
   .PRIV_W (PRIV_W),
   .MAX_INC(pmc_pkg::MASK_W)
) u_pmc_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .acc_en  (acc_en),
   .acc_priv(acc_priv),
   .wdata_lo(acc_wdata[CNT_W-1:0]),
   .ctl_we  (ctl_we),
   .cnt_we  (cnt_we),
   .en_vec  (en_vec),
   .dur_vec (dur_vec),
   .ovf_vec (ovf_vec),
   .cnt_flat(cnt_flat)
);

// File: tb/tb_evq_perf_counters.sv
`timescale 1ns/1ps
module tb_evq_perf_counters;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ev_lines = '0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [1:0]  acc_addr = '0;
   logic [1:0]  acc_priv = '0;
   logic [63:0] acc_wdata = '0;
   logic [63:0] acc_rdata;
   logic        acc_fault;
   logic        rd_sel = 1'b0;
   logic [39:0] rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evq_perf_counters dut (
      .clk(clk), .rst_n(rst_n), .ev_lines(ev_lines),
      .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_priv(acc_priv),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_fault(acc_fault),
      .rd_sel(rd_sel), .rd_data(rd_data)
   );

   // {control word, event lines, cycles, expected count}
   localparam logic [143:0] VEC [8] = '{
      {32'h0010_FF02, 64'h0000_0000_000F_0000, 8'd3, 40'd12},
      {32'h0010_0502, 64'h0000_0000_000F_0000, 8'd3, 40'd6},
      {32'h0011_0502, 64'h0000_0000_000F_0000, 8'd3, 40'd3},
      {32'h0011_F002, 64'h0000_0000_000F_0000, 8'd3, 40'd0},
      {32'h0010_FF05, 64'h0000_0000_000F_0000, 8'd3, 40'd0},
      {32'h0010_8105, 64'h0000_FF00_0000_0000, 8'd4, 40'd8},
      {32'h0000_FF02, 64'h0000_0000_00FF_0000, 8'd3, 40'd0},
      {32'h0010_FF09, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 40'd0}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic acc_write(input logic [1:0] a, input logic [63:0] d, input logic [1:0] p,
                            output logic f);
      acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_priv = p;
      #1 f = acc_fault;
      tick();
      acc_en = 1'b0; acc_wr = 1'b0; acc_priv = '0;
   endtask

   task automatic acc_read(input logic [1:0] a, input logic [1:0] p,
                           output logic [63:0] d, output logic f);
      acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_priv = p;
      #1 d = acc_rdata; f = acc_fault;
      acc_en = 1'b0; acc_priv = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic        f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         acc_read(2'(a), 2'd0, d, f);
         check("R1 reset register", d, 64'd0);
      end
      rd_sel = 1'b0; #1 check("R1 R9 reset counter 0", 64'(rd_data), 64'd0);
      rd_sel = 1'b1; #1 check("R1 R9 reset counter 1", 64'(rd_data), 64'd0);
      rd_sel = 1'b0;

      // R3/R4/R5/R2: vector table on counter 0
      for (int i = 0; i < 8; i++) begin
         logic [31:0] cw;
         string       tag;
         cw = VEC[i][143:112];
         acc_write(2'd0, 64'(cw), 2'd0, f);
         acc_write(2'd2, 64'd0, 2'd0, f);
         ev_lines = VEC[i][111:48];
         repeat (int'(VEC[i][47:40])) tick();
         ev_lines = '0;
         if (!cw[20])            tag = "R5 disabled holds";
         else if (cw[7:0] >= 8)  tag = "R2 select out of range";
         else if (cw[16])        tag = "R4 cycle mode";
         else                    tag = "R3 event mode";
         rd_sel = 1'b0;
         #1 check($sformatf("%s vector %0d", tag, i), 64'(rd_data), 64'(VEC[i][39:0]));
      end

      // R2: control readback drops unused bits
      acc_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, f);
      acc_read(2'd0, 2'd0, d, f);
      check("R2 control readback", d, 64'h0000_0000_8011_FFFF);
      acc_write(2'd0, 64'd0, 2'd0, f);

      // R1/R3: counter 1 runs independently of counter 0
      acc_write(2'd2, 64'd77, 2'd0, f);
      acc_write(2'd1, 64'h0010_0100, 2'd0, f);
      acc_write(2'd3, 64'd0, 2'd0, f);
      ev_lines = 64'h0000_0000_0000_0001;
      repeat (5) tick();
      ev_lines = '0;
      rd_sel = 1'b1; #1 check("R3 R9 counter 1 own source", 64'(rd_data), 64'd5);
      rd_sel = 1'b0; #1 check("R1 counter 0 untouched", 64'(rd_data), 64'd77);

      // R6: wrap and sticky overflow
      acc_write(2'd0, 64'h0010_FF02, 2'd0, f);
      acc_write(2'd2, 64'h00FF_FFFF_FFFE, 2'd0, f);
      ev_lines = 64'h0000_0000_0007_0000;
      tick();
      ev_lines = '0;
      #1 check("R6 wrap value", 64'(rd_data), 64'd1);
      acc_read(2'd0, 2'd0, d, f);
      check("R6 overflow set", d, 64'h0000_0000_8010_FF02);
      repeat (3) tick();
      acc_read(2'd0, 2'd0, d, f);
      check("R6 overflow sticky", d, 64'h0000_0000_8010_FF02);
      acc_write(2'd0, 64'h0010_FF02, 2'd0, f);
      acc_read(2'd0, 2'd0, d, f);
      check("R6 overflow cleared by write", d, 64'h0000_0000_0010_FF02);

      // R7: counter load replaces live increment
      ev_lines = 64'h0000_0000_00FF_0000;
      acc_write(2'd2, 64'd100, 2'd0, f);
      ev_lines = '0;
      #1 check("R7 load wins over increment", 64'(rd_data), 64'd100);

      // R7: zero extension through access port
      acc_write(2'd1, 64'd0, 2'd0, f);
      acc_write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, f);
      acc_read(2'd3, 2'd0, d, f);
      check("R7 counter read zero-extended", d, 64'h0000_00FF_FFFF_FFFF);
      rd_sel = 1'b1; #1 check("R9 read port counter 1", 64'(rd_data), 64'hFF_FFFF_FFFF);
      rd_sel = 1'b0;

      // R8: privilege checks
      acc_write(2'd2, 64'h55, 2'd3, f);
      check("R8 write fault flag", 64'(f), 64'd1);
      acc_read(2'd2, 2'd0, d, f);
      check("R8 counter unchanged", d, 64'd100);
      acc_read(2'd0, 2'd1, d, f);
      check("R8 read fault flag", 64'(f), 64'd1);
      check("R8 read data zero", d, 64'd0);
      acc_write(2'd0, 64'd0, 2'd2, f);
      acc_read(2'd0, 2'd0, d, f);
      check("R8 control unchanged", d, 64'h0000_0000_0010_FF02);
      check("R8 level 0 no fault", 64'(f), 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule